// File: doc/BRIEF.md
# Outbound MMIO Window Group Decoder

This block sits on the outbound path of a host bridge. It compares each CPU address against one 32-bit window and sixteen 64-bit windows. On a hit it returns the PCIe address to issue and the isolation group that owns the access. Group numbers are 8 bits wide. Another block uses them later to drop or poison traffic for a frozen group; that filtering is not done here.

The 32-bit window has two functions:
- It rewrites the address bits above its size with a programmed value.
- It divides its range into 256 equal segments and maps each segment to a group through a programmable 256-entry table.

A 64-bit window never changes the address. It runs in one of two modes:
- Unsegmented: it returns one programmed group for its whole range.
- Segmented: its range has 256 segments, and the segment index is the group number.

Configuration uses a single write port. A write that asks for an impossible window size, or a base that is not aligned to that size, is refused. The previous setting of that window is kept.

A lookup is a single-cycle request. Its result is registered and appears on the cycle after `req_valid`.

Top module: `mmio_window_decoder`

## Requirements
- R1: A 64-bit window hits when it is enabled and the address bits at and above its log2 size equal its base. A 64-bit hit forwards the CPU address unchanged as `out_addr`, and `out_src` gives the window index 0..15.
- R2: An unsegmented 64-bit window hit returns the group programmed for that window.
- R3: A segmented 64-bit window hit returns bits [7:0] of (address − base) shifted right by (log2 size − 8).
- R4: When several enabled 64-bit windows cover an address, the lowest-numbered one supplies the result.
- R5: Any 64-bit hit takes precedence over the 32-bit window. The 32-bit window is used only when no 64-bit window hits, and then `out_src` = 16.
- R6: On a 32-bit window hit, `out_addr` takes its bits below the window's log2 size from the CPU address and all higher bits from the programmed remap value.
- R7: On a 32-bit window hit, the group is the table entry indexed by ((address − base) >> (log2 size − 8))[7:0].
- R8: An address that hits no enabled window gives `out_miss` = 1 and `out_valid` = 0. A hit gives `out_valid` = 1 and `out_miss` = 0. Both flags appear the cycle after `req_valid`.
- R9: Configuration writes use these `cfg_kind` codes:
  - 0: writes the 64-bit window selected by `cfg_win`.
  - 1: writes the 32-bit window.
  - 2: writes table entry `cfg_entry` with `cfg_group`.
  - 3: has no effect and is never rejected.

  A window write is rejected, with `cfg_reject` = 1 on the next cycle and no change to that window, if the base is not aligned to 2^`cfg_log2` or if the size is out of range. The allowed size is `cfg_log2` ≥ 28 for a 64-bit window and 8..32 for the 32-bit window.
- R10: After reset every window is disabled, every table entry is 0, and `out_valid`, `out_miss` and `cfg_reject` are 0.
- R11: `out_valid` and `out_miss` both stay 0 on the cycle after a cycle without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 = 64-bit window, 1 = 32-bit window, 2 = table entry, 3 = none |
| cfg_win | input | 4 | 64-bit window index |
| cfg_entry | input | 8 | Segment table entry index |
| cfg_base | input | 64 | Window base address |
| cfg_log2 | input | 6 | Window size as log2 bytes |
| cfg_enable | input | 1 | Window enable |
| cfg_segmented | input | 1 | 64-bit window segmented mode |
| cfg_group | input | 8 | Group for an unsegmented window or a table entry |
| cfg_remap | input | 64 | Replacement upper bits for the 32-bit window |
| cfg_reject | output | 1 | The previous cycle's window write was refused |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | CPU address to decode |
| out_valid | output | 1 | Hit, issue the PCIe request |
| out_miss | output | 1 | No window matched |
| out_addr | output | 64 | PCIe address |
| out_group | output | 8 | Isolation group number |
| out_src | output | 5 | Winning window: 0..15 for a 64-bit window, 16 for the 32-bit window |

## Verification
The hardest case to produce is one address covered by several windows at once: two 64-bit windows of different sizes, with the 32-bit window lying underneath them. Random window placement rarely nests windows like this. The bench therefore builds one directed stack: a large segmented window at a higher index, a small unsegmented window at a lower index inside it, and a 4 GB 64-bit window over the 32-bit window. It then probes addresses inside and outside each layer, and repeats the probes after a window is disabled. Refused writes are checked by looking up addresses in the window afterwards, which shows its old setting still decodes.

// File: rtl/owd_pkg.sv
package owd_pkg;
  localparam int ADDR_W   = 64;
  localparam int SEG_BITS = 8;
  localparam int LG_W     = 6;

  localparam logic [1:0] KIND_WIN64 = 2'd0;
  localparam logic [1:0] KIND_WIN32 = 2'd1;
  localparam logic [1:0] KIND_TABLE = 2'd2;

  // Mask of offset bits inside a 2^lg window
  function automatic logic [ADDR_W-1:0] off_mask(input logic [LG_W-1:0] lg);
    return (ADDR_W'(1) << lg) - ADDR_W'(1);
  endfunction

  function automatic logic base_aligned(input logic [ADDR_W-1:0] b,
                                        input logic [LG_W-1:0] lg);
    return (b & off_mask(lg)) == '0;
  endfunction

  // Segment index: offset shifted so that 2^SEG_BITS segments span the window
  function automatic logic [SEG_BITS-1:0] seg_of(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] base,
                                                 input logic [LG_W-1:0] lg);
    logic [ADDR_W-1:0] off;
    off = (a - base) >> (lg - LG_W'(SEG_BITS));
    return off[SEG_BITS-1:0];
  endfunction
endpackage

// File: rtl/owd_prio_pick.sv
module owd_prio_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R4
  winner_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]) else $error("winner not requesting");
  // R4
  no_lower_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & ((N'(1) << idx) - N'(1))) == '0)) else $error("lower window skipped");
endmodule

// File: rtl/owd_win64_bank.sv
module owd_win64_bank
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int MIN_LG  = 28,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [ADDR_W-1:0]                 wr_base,
  input  logic [LG_W-1:0]                   wr_lg,
  input  logic                              wr_enable,
  input  logic                              wr_seg,
  input  logic [SEG_BITS-1:0]               wr_grp,
  input  logic [ADDR_W-1:0]                 lk_addr,
  output logic                              wr_bad,
  output logic [NUM_WIN-1:0]                hit_vec,
  output logic [NUM_WIN-1:0][SEG_BITS-1:0]  grp_vec
);
  logic [NUM_WIN-1:0]               en_q;
  logic [NUM_WIN-1:0]               seg_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0]   base_q;
  logic [NUM_WIN-1:0][LG_W-1:0]     lg_q;
  logic [NUM_WIN-1:0][SEG_BITS-1:0] grp_q;

  assign wr_bad = wr_en && ((wr_lg < LG_W'(MIN_LG)) || !base_aligned(wr_base, wr_lg));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[w]   <= 1'b0;
        seg_q[w]  <= 1'b0;
        base_q[w] <= '0;
        lg_q[w]   <= LG_W'(MIN_LG);
        grp_q[w]  <= '0;
      end else if (wr_en && !wr_bad && wr_idx == IDX_W'(w)) begin
        en_q[w]   <= wr_enable;
        seg_q[w]  <= wr_seg;
        base_q[w] <= wr_base;
        lg_q[w]   <= wr_lg;
        grp_q[w]  <= wr_grp;
      end
    end
    assign hit_vec[w] = en_q[w] && ((lk_addr & ~off_mask(lg_q[w])) == base_q[w]);
    assign grp_vec[w] = seg_q[w] ? seg_of(lk_addr, base_q[w], lg_q[w]) : grp_q[w];
  end

  // R9
  bad64_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(base_q) && $stable(lg_q) && $stable(en_q))) else $error("rejected write changed window");
endmodule

// File: rtl/owd_win32.sv
module owd_win32
  import owd_pkg::*;
#(
  parameter int MIN_LG = SEG_BITS,
  parameter int MAX_LG = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_base,
  input  logic [LG_W-1:0]     wr_lg,
  input  logic                wr_enable,
  input  logic [ADDR_W-1:0]   wr_remap,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                wr_bad,
  output logic                hit,
  output logic [ADDR_W-1:0]   pci_addr,
  output logic [SEG_BITS-1:0] seg_idx
);
  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] remap_q;
  logic [LG_W-1:0]   lg_q;
  logic [ADDR_W-1:0] mask;

  assign wr_bad = wr_en && ((wr_lg < LG_W'(MIN_LG)) || (wr_lg > LG_W'(MAX_LG)) ||
                            !base_aligned(wr_base, wr_lg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      base_q  <= '0;
      remap_q <= '0;
      lg_q    <= LG_W'(MAX_LG);
    end else if (wr_en && !wr_bad) begin
      en_q    <= wr_enable;
      base_q  <= wr_base;
      remap_q <= wr_remap;
      lg_q    <= wr_lg;
    end
  end

  assign mask     = off_mask(lg_q);
  assign hit      = en_q && ((lk_addr & ~mask) == base_q);
  assign pci_addr = (remap_q & ~mask) | (lk_addr & mask);
  assign seg_idx  = seg_of(lk_addr, base_q, lg_q);

  // R9
  bad32_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(base_q) && $stable(lg_q) && $stable(remap_q))) else $error("rejected 32-bit write applied");
endmodule

// File: rtl/owd_seg_table.sv
module owd_seg_table
  import owd_pkg::*;
#(
  parameter int ENTRIES = 1 << SEG_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_BITS-1:0] wr_idx,
  input  logic [SEG_BITS-1:0] wr_grp,
  input  logic [SEG_BITS-1:0] rd_idx,
  output logic [SEG_BITS-1:0] rd_grp
);
  logic [ENTRIES-1:0][SEG_BITS-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tbl_q <= '0;
    else if (wr_en) tbl_q[wr_idx] <= wr_grp;
  end

  assign rd_grp = tbl_q[rd_idx];
endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int MIN_LG64 = 28,
  parameter int MAX_LG32 = 32,
  localparam int IDX_W = $clog2(NUM_WIN),
  localparam int SRC_W = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [IDX_W-1:0]    cfg_win,
  input  logic [SEG_BITS-1:0] cfg_entry,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [LG_W-1:0]     cfg_log2,
  input  logic                cfg_enable,
  input  logic                cfg_segmented,
  input  logic [SEG_BITS-1:0] cfg_group,
  input  logic [ADDR_W-1:0]   cfg_remap,
  output logic                cfg_reject,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                out_valid,
  output logic                out_miss,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [SEG_BITS-1:0] out_group,
  output logic [SRC_W-1:0]    out_src
);
  logic                             bad64, bad32, hit32, any64;
  logic [NUM_WIN-1:0]               hit_vec;
  logic [NUM_WIN-1:0][SEG_BITS-1:0] grp_vec;
  logic [IDX_W-1:0]                 win_idx;
  logic [ADDR_W-1:0]                pci32;
  logic [SEG_BITS-1:0]              seg32, grp32;

  owd_win64_bank #(.NUM_WIN(NUM_WIN), .MIN_LG(MIN_LG64)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && cfg_kind == KIND_WIN64), .wr_idx(cfg_win),
    .wr_base(cfg_base), .wr_lg(cfg_log2), .wr_enable(cfg_enable),
    .wr_seg(cfg_segmented), .wr_grp(cfg_group), .lk_addr(req_addr),
    .wr_bad(bad64), .hit_vec(hit_vec), .grp_vec(grp_vec));

  owd_prio_pick #(.N(NUM_WIN)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(hit_vec), .any(any64), .idx(win_idx));

  owd_win32 #(.MAX_LG(MAX_LG32)) u_w32 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && cfg_kind == KIND_WIN32), .wr_base(cfg_base),
    .wr_lg(cfg_log2), .wr_enable(cfg_enable), .wr_remap(cfg_remap),
    .lk_addr(req_addr), .wr_bad(bad32), .hit(hit32),
    .pci_addr(pci32), .seg_idx(seg32));

  owd_seg_table u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && cfg_kind == KIND_TABLE), .wr_idx(cfg_entry),
    .wr_grp(cfg_group), .rd_idx(seg32), .rd_grp(grp32));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_reject <= 1'b0;
      out_valid  <= 1'b0;
      out_miss   <= 1'b0;
      out_addr   <= '0;
      out_group  <= '0;
      out_src    <= '0;
    end else begin
      cfg_reject <= bad64 || bad32;
      out_valid  <= req_valid && (any64 || hit32);
      out_miss   <= req_valid && !(any64 || hit32);
      if (req_valid) begin
        out_addr  <= any64 ? req_addr : pci32;
        out_group <= any64 ? grp_vec[win_idx] : grp32;
        out_src   <= any64 ? SRC_W'(win_idx) : SRC_W'(NUM_WIN);
      end
    end
  end

  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_miss)) else $error("hit and miss together");
  // R11
  resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_miss) |-> $past(req_valid)) else $error("response without request");
  // R1
  passthru64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_src < SRC_W'(NUM_WIN)) |-> out_addr == $past(req_addr)) else $error("64-bit address altered");
  // R5
  w32_only_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any64) |=> out_src != SRC_W'(NUM_WIN)) else $error("32-bit window beat 64-bit");
endmodule

// File: tb/mmio_window_decoder_bench.sv
module mmio_window_decoder_bench;
  localparam int NW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [3:0]  cfg_win = '0;
  logic [7:0]  cfg_entry = '0;
  logic [63:0] cfg_base = '0;
  logic [5:0]  cfg_log2 = '0;
  logic        cfg_enable = 1'b0;
  logic        cfg_segmented = 1'b0;
  logic [7:0]  cfg_group = '0;
  logic [63:0] cfg_remap = '0;
  logic        cfg_reject;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        out_valid, out_miss;
  logic [63:0] out_addr;
  logic [7:0]  out_group;
  logic [4:0]  out_src;

  always #2 clk = ~clk;

  mmio_window_decoder u_mmio_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_win(cfg_win), .cfg_entry(cfg_entry), .cfg_base(cfg_base),
    .cfg_log2(cfg_log2), .cfg_enable(cfg_enable), .cfg_segmented(cfg_segmented),
    .cfg_group(cfg_group), .cfg_remap(cfg_remap), .cfg_reject(cfg_reject),
    .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
    .out_miss(out_miss), .out_addr(out_addr), .out_group(out_group),
    .out_src(out_src));

  int checks = 0;
  int fails  = 0;

  // bench model of the programmed state
  bit          m_en[NW];
  bit          m_seg[NW];
  logic [63:0] m_base[NW];
  int          m_lg[NW];
  logic [7:0]  m_grp[NW];
  bit          w_en = 0;
  logic [63:0] w_base = 0, w_remap = 0;
  int          w_lg = 32;
  logic [7:0]  tbl[256];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit inside_win(input logic [63:0] a, input logic [63:0] b, input int lg);
    return ((a ^ b) >> lg) == 64'd0;
  endfunction

  task automatic model(input logic [63:0] a, output bit hit, output logic [63:0] pa,
                       output logic [7:0] g, output logic [4:0] src);
    logic [63:0] lowbits;
    hit = 0; pa = 0; g = 0; src = 0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (m_en[i] && inside_win(a, m_base[i], m_lg[i])) begin
        hit = 1; src = 5'(i); pa = a;
        g = m_seg[i] ? 8'((a - m_base[i]) / (64'd1 << (m_lg[i] - 8))) : m_grp[i];
      end
    end
    if (!hit && w_en && inside_win(a, w_base, w_lg)) begin
      lowbits = a % (64'd1 << w_lg);
      hit = 1; src = 5'd16;
      pa = ((w_remap >> w_lg) << w_lg) + lowbits;
      g = tbl[8'(lowbits / (64'd1 << (w_lg - 8)))];
    end
  endtask

  task automatic lookup(input logic [63:0] a, input string tag);
    bit hit; logic [63:0] pa; logic [7:0] g; logic [4:0] src;
    model(a, hit, pa, g, src);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    check({tag, " valid"}, 64'(out_valid), 64'(hit));
    check({tag, " miss"}, 64'(out_miss), 64'(!hit));
    if (hit) begin
      check({tag, " addr"}, out_addr, pa);
      check({tag, " group"}, 64'(out_group), 64'(g));
      check({tag, " src"}, 64'(out_src), 64'(src));
    end
  endtask

  task automatic cfg_write(input logic [1:0] kind, input int win, input logic [7:0] entry,
                           input logic [63:0] base, input int lg, input bit en, input bit seg,
                           input logic [7:0] grp, input logic [63:0] remap, input string tag);
    bit bad;
    bad = 0;
    if (kind == 2'd0) bad = (lg < 28) || (base % (64'd1 << lg) != 0);
    if (kind == 2'd1) bad = (lg < 8) || (lg > 32) || (base % (64'd1 << lg) != 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_win = 4'(win); cfg_entry = entry;
    cfg_base = base; cfg_log2 = 6'(lg); cfg_enable = en; cfg_segmented = seg;
    cfg_group = grp; cfg_remap = remap;
    @(negedge clk); cfg_we = 1'b0;
    check({tag, " reject"}, 64'(cfg_reject), 64'(bad));
    if (!bad) begin
      if (kind == 2'd0) begin
        m_en[win] = en; m_seg[win] = seg; m_base[win] = base; m_lg[win] = lg; m_grp[win] = grp;
      end else if (kind == 2'd1) begin
        w_en = en; w_base = base; w_lg = lg; w_remap = remap;
      end else if (kind == 2'd2) begin
        tbl[entry] = grp;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] a, b;
    int lg, w;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 0; m_seg[i] = 0; m_base[i] = 0; m_lg[i] = 28; m_grp[i] = 0;
    end
    for (int i = 0; i < 256; i++) tbl[i] = 0;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", 64'(out_valid), 0);
    check("R10 out_miss", 64'(out_miss), 0);
    check("R10 cfg_reject", 64'(cfg_reject), 0);
    rst_n = 1'b1;
    lookup(64'h8000_0000, "R10 all disabled R8");

    // 32-bit window: 2 GB at 0x8000_0000, remap upper bits
    for (int i = 0; i < 256; i++) cfg_write(2'd2, 0, 8'(i), 0, 0, 0, 0, 8'(i) ^ 8'h5A, 0, "R7 table");
    cfg_write(2'd1, 0, 0, 64'h8000_0000, 31, 1, 0, 0, 64'hDEAD_BEEF_8000_0000, "R6 w32 cfg");
    lookup(64'h8000_0000 + 5 * 64'h80_0000 + 3, "R6 R7 w32 seg5");
    lookup(64'hFFFF_FFF0, "R6 R7 w32 top seg");
    lookup(64'h7FFF_FFFF, "R8 below w32");

    // R11 idle cycle produces nothing
    @(negedge clk);
    check("R11 idle valid", 64'(out_valid), 0);
    check("R11 idle miss", 64'(out_miss), 0);

    // nested 64-bit windows
    cfg_write(2'd0, 3, 0, 64'h10_0000_0000, 36, 1, 1, 0, 0, "R3 win3 cfg");
    cfg_write(2'd0, 1, 0, 64'h10_4000_0000, 30, 1, 0, 8'h77, 0, "R2 win1 cfg");
    lookup(64'h10_4000_1234, "R4 overlap lowest wins R2");
    lookup(64'h10_C123_4567, "R3 segmented win3");
    lookup(64'h1F_FFFF_FFFF, "R3 last segment");
    cfg_write(2'd0, 5, 0, 64'h0, 32, 1, 0, 8'h11, 0, "R5 win5 cfg");
    lookup(64'h8000_1000, "R5 64-bit over 32-bit");
    cfg_write(2'd0, 5, 0, 64'h0, 32, 0, 0, 8'h11, 0, "R5 win5 disable");
    lookup(64'h8000_1000, "R5 32-bit after disable");

    // R9 rejected writes keep the old setting
    cfg_write(2'd0, 1, 0, 64'h10_4000_1000, 30, 1, 0, 8'h99, 0, "R9 misaligned 64");
    lookup(64'h10_4000_0010, "R9 win1 unchanged");
    cfg_write(2'd0, 2, 0, 64'h2_0000_0000, 20, 1, 0, 8'h22, 0, "R9 too small 64");
    lookup(64'h2_0000_0000, "R9 win2 stays off");
    cfg_write(2'd1, 0, 0, 64'h0, 33, 1, 0, 0, 64'h0, "R9 w32 too large");
    lookup(64'h8000_0040, "R9 w32 unchanged");
    cfg_write(2'd3, 0, 0, 64'h123, 4, 1, 1, 8'hFF, 0, "R9 kind3 ignored");
    lookup(64'h8000_0040, "R9 kind3 no effect");

    // constrained random
    for (int r = 0; r < 40; r++) begin
      w  = $urandom_range(0, NW - 1);
      lg = $urandom_range(28, 40);
      b  = {$urandom, $urandom} & 64'h0000_0FFF_FFFF_FFFF;
      b  = (b >> lg) << lg;
      if ($urandom_range(0, 7) == 0) b = b | 64'h1000;
      cfg_write(2'd0, w, 0, b, lg, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                8'($urandom), 0, "random R9 cfg");
      for (int k = 0; k < 20; k++) begin
        w = $urandom_range(0, NW - 1);
        if (m_en[w] && $urandom_range(0, 4) != 0)
          a = m_base[w] + ({$urandom, $urandom} % (64'd1 << m_lg[w]));
        else if ($urandom_range(0, 3) == 0)
          a = 64'h8000_0000 + 64'($urandom_range(0, 32'h7FFF_FFFF));
        else
          a = {$urandom, $urandom} & 64'h0000_0FFF_FFFF_FFFF;
        lookup(a, "random R1 R2 R3 R4 R6 R7");
      end
    end
    summary();
  end
endmodule